// File: doc/BRIEF.md
# Invalidate Queue with Barrier Marking

This block is a per-core holding queue for coherence invalidations, placed between the interconnect and a private cache. An incoming invalidate is acknowledged in the cycle it is taken. It is then applied to the cache tag port later, one per cycle at most and in arrival order. This lets the interconnect move on without waiting for the tag array.

Barrier commands come in three kinds. A read or a full barrier tags every invalidate held in the queue at that moment. Loads are then held back until those tagged entries have reached the cache. The queue is not forced to empty: tagged entries leave at the normal pace of the tag port. Invalidates arriving later stay untagged and do not lengthen the hold. A write barrier leaves the queue alone.

On the store-buffer side, a read barrier raises a check request and a write barrier raises a mark request. A full barrier raises both. A build option replaces tagging with a complete drain, which suits a simple in-order core: intake closes and loads are held until the queue is empty.

Top module: `invq_barrier_top`

## Requirements
- R1: After reset the queue is empty: `inv_ready` is 1, and `tag_inv_valid`, `load_stall`, `sb_snoop` and `sb_mark` are 0, with `marked_count` at 0.
- R2: An invalidate is taken when `inv_valid` and `inv_ready` are both 1, and `inv_ack` is 1 in that same cycle. `inv_ready` is 0 while DEPTH entries are held.
- R3: The queue presents its oldest entry on `tag_inv_valid`/`tag_inv_line`. That entry leaves in a cycle where `tag_inv_ready` is 1, so entries leave in arrival order, at most one per cycle. While `tag_inv_ready` is 0, the presented line holds steady.
- R4: `bar_kind` is encoded as 01 read, 10 write and 11 full. When `bar_valid` is 1 with bit 0 of `bar_kind` set, `marked_count` in the next cycle equals the queue occupancy after that cycle's intake and removal. This occupancy includes an invalidate taken in the same cycle.
- R5: `load_stall` is 1 exactly when marked entries remain (in the default mode). `ld_go` equals `ld_req` when `load_stall` is 0, and is 0 otherwise.
- R6: Each entry removed while `marked_count` is non-zero lowers `marked_count` by one. A barrier does not speed up removal, so with `tag_inv_ready` at 0 the count holds.
- R7: Invalidates taken after a barrier are unmarked. The hold ends once the earlier entries are gone, even with newer entries still queued.
- R8: A second read or full barrier issued while marked entries remain marks every entry then present.
- R9: A write barrier does not change `marked_count` and does not raise `load_stall`.
- R10: One cycle after a barrier, `sb_snoop` pulses for read and full barriers and `sb_mark` pulses for write and full barriers. A `bar_kind` of 00 has no effect.
- R11: With DRAIN_ON_BAR set, a read or full barrier on a non-empty queue drives `inv_ready` to 0 and `load_stall` to 1 until the queue is empty.
- R12: A load whose line matches a marked entry still in the queue never receives `ld_go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_valid | input | 1 | Incoming invalidate present |
| inv_line | input | LINE_W | Line address to invalidate |
| inv_ready | output | 1 | Queue can take an invalidate |
| inv_ack | output | 1 | Invalidate taken this cycle |
| bar_valid | input | 1 | Barrier command present |
| bar_kind | input | 2 | 01 read, 10 write, 11 full, 00 none |
| sb_snoop | output | 1 | Pulse: store buffer check request |
| sb_mark | output | 1 | Pulse: store buffer mark request |
| tag_inv_valid | output | 1 | Oldest entry offered to the tag port |
| tag_inv_line | output | LINE_W | Line of the oldest entry |
| tag_inv_ready | input | 1 | Tag port applies the offered entry |
| ld_req | input | 1 | Core wants to issue a load |
| ld_go | output | 1 | Load may issue this cycle |
| load_stall | output | 1 | Marked entries remain; loads held |
| marked_count | output | $clog2(DEPTH+1) | Number of marked entries still queued |

## Verification
Three things can coincide in one cycle: a read barrier, the intake of a fresh invalidate, and the removal of the oldest entry. The bench sets up this case by holding two entries and then raising `bar_valid`, `inv_valid` and `tag_inv_ready` together. It expects `marked_count` to read two in the next cycle, because the new entry counts as marked and the removed one does not. It also expects the second queued line to be on offer. The drain from full and the stall release under a stream of later arrivals are judged by comparing the presented lines and `ld_go`, cycle by cycle, against the order in which lines were sent.

// File: rtl/invq_pkg.sv
package invq_pkg;

  typedef enum logic [1:0] {
    BAR_NONE  = 2'b00,
    BAR_READ  = 2'b01,
    BAR_WRITE = 2'b10,
    BAR_FULL  = 2'b11
  } bar_kind_e;

  // bit 0: the barrier orders loads (tags the invalidate queue)
  function automatic logic bar_tags_queue(input logic [1:0] kind);
    return kind[0];
  endfunction

  // bit 1: the barrier orders stores (mark request to the store buffer)
  function automatic logic bar_tags_stores(input logic [1:0] kind);
    return kind[1];
  endfunction

endpackage

// File: rtl/invq_fifo.sv
module invq_fifo #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [LINE_W-1:0]            push_line,
  input  logic                         pop,
  output logic [LINE_W-1:0]            head_line,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [LINE_W-1:0] store_mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) store_mem[wr_ptr] <= push_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_line = store_mem[rd_ptr];
  assign count     = cnt_q;
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/invq_mark_ctrl.sv
module invq_mark_ctrl #(
  parameter int DEPTH        = 8,
  parameter bit DRAIN_ON_BAR = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bar_tag,
  input  logic                        push,
  input  logic                        pop,
  input  logic [$clog2(DEPTH+1)-1:0]  count,
  output logic [$clog2(DEPTH+1)-1:0]  marked_count,
  output logic                        load_stall,
  output logic                        drain_hold
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] count_next;
  logic [CNT_W-1:0] marked_q, marked_n;
  logic             drain_q, drain_n;
  logic             stall_q;

  // Marked entries always form a prefix from the head of the FIFO,
  // so one counter replaces a mark bit per entry.
  always_comb begin
    count_next = count + CNT_W'(push) - CNT_W'(pop);
    if (bar_tag)
      marked_n = count_next;
    else if (pop && (marked_q != '0))
      marked_n = marked_q - CNT_W'(1);
    else
      marked_n = marked_q;
  end

  generate
    if (DRAIN_ON_BAR) begin : g_full_drain
      always_comb begin
        if (count_next == '0)
          drain_n = 1'b0;
        else if (bar_tag)
          drain_n = 1'b1;
        else
          drain_n = drain_q;
      end
    end else begin : g_tag_only
      assign drain_n = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      marked_q <= '0;
      drain_q  <= 1'b0;
      stall_q  <= 1'b0;
    end else begin
      marked_q <= marked_n;
      drain_q  <= drain_n;
      stall_q  <= (marked_n != '0) || drain_n;
    end
  end

  assign marked_count = marked_q;
  assign load_stall   = stall_q;
  assign drain_hold   = drain_q;

endmodule

// File: rtl/invq_sb_req.sv
module invq_sb_req
  import invq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bar_valid,
  input  logic [1:0] bar_kind,
  output logic       sb_snoop,
  output logic       sb_mark
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sb_snoop <= 1'b0;
      sb_mark  <= 1'b0;
    end else begin
      sb_snoop <= bar_valid && bar_tags_queue(bar_kind);
      sb_mark  <= bar_valid && bar_tags_stores(bar_kind);
    end
  end
endmodule

// File: rtl/invq_barrier_top.sv
module invq_barrier_top
  import invq_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int LINE_W       = 26,
  parameter bit DRAIN_ON_BAR = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inv_valid,
  input  logic [LINE_W-1:0]           inv_line,
  output logic                        inv_ready,
  output logic                        inv_ack,
  input  logic                        bar_valid,
  input  logic [1:0]                  bar_kind,
  output logic                        sb_snoop,
  output logic                        sb_mark,
  output logic                        tag_inv_valid,
  output logic [LINE_W-1:0]           tag_inv_line,
  input  logic                        tag_inv_ready,
  input  logic                        ld_req,
  output logic                        ld_go,
  output logic                        load_stall,
  output logic [$clog2(DEPTH+1)-1:0]  marked_count
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic             push, pop, empty, full, drain_hold, bar_tag;
  logic [CNT_W-1:0] count;

  assign inv_ready     = !full && !drain_hold;
  assign inv_ack       = inv_valid && inv_ready;
  assign push          = inv_ack;
  assign tag_inv_valid = !empty;
  assign pop           = tag_inv_valid && tag_inv_ready;
  assign bar_tag       = bar_valid && bar_tags_queue(bar_kind);
  assign ld_go         = ld_req && !load_stall;

  invq_fifo #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_line (inv_line),
    .pop       (pop),
    .head_line (tag_inv_line),
    .count     (count),
    .empty     (empty),
    .full      (full)
  );

  invq_mark_ctrl #(.DEPTH(DEPTH), .DRAIN_ON_BAR(DRAIN_ON_BAR)) u_mark (
    .clk          (clk),
    .rst          (rst),
    .bar_tag      (bar_tag),
    .push         (push),
    .pop          (pop),
    .count        (count),
    .marked_count (marked_count),
    .load_stall   (load_stall),
    .drain_hold   (drain_hold)
  );

  invq_sb_req u_sb (
    .clk       (clk),
    .rst       (rst),
    .bar_valid (bar_valid),
    .bar_kind  (bar_kind),
    .sb_snoop  (sb_snoop),
    .sb_mark   (sb_mark)
  );

endmodule

// File: rtl/invq_barrier_chk.sv
module invq_barrier_chk #(
  parameter int DEPTH  = 8,
  parameter int LINE_W = 26
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        inv_ack,
  input logic                        bar_valid,
  input logic [1:0]                  bar_kind,
  input logic                        sb_snoop,
  input logic                        sb_mark,
  input logic                        tag_inv_valid,
  input logic [LINE_W-1:0]           tag_inv_line,
  input logic                        tag_inv_ready,
  input logic [$clog2(DEPTH+1)-1:0]  marked_count
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [CNT_W-1:0] occ_q;
  logic             leave;

  assign leave = tag_inv_valid && tag_inv_ready;

  // occupancy rebuilt from the port handshakes only
  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= occ_q + CNT_W'(inv_ack) - CNT_W'(leave);
  end

  a_r2_occupancy_bounded: assert property (@(posedge clk) disable iff (rst)
    occ_q <= CNT_W'(DEPTH));

  a_r3_valid_tracks_occupancy: assert property (@(posedge clk) disable iff (rst)
    tag_inv_valid == (occ_q != '0));

  a_r3_head_held: assert property (@(posedge clk) disable iff (rst)
    (tag_inv_valid && !tag_inv_ready) |=> (tag_inv_valid && $stable(tag_inv_line)));

  a_r4_mark_all_present: assert property (@(posedge clk) disable iff (rst)
    (bar_valid && bar_kind[0]) |=> (marked_count == occ_q));

  a_r6_marks_within_queue: assert property (@(posedge clk) disable iff (rst)
    marked_count <= occ_q);

  a_r6_marks_never_grow: assert property (@(posedge clk) disable iff (rst)
    !(bar_valid && bar_kind[0]) |=> (marked_count <= $past(marked_count)));

  a_r9_write_leaves_marks: assert property (@(posedge clk) disable iff (rst)
    (bar_valid && bar_kind == 2'b10 && !leave) |=> (marked_count == $past(marked_count)));

  a_r10_full_requests_both: assert property (@(posedge clk) disable iff (rst)
    (bar_valid && bar_kind == 2'b11) |=> (sb_snoop && sb_mark));

endmodule

bind invq_barrier_top invq_barrier_chk #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .inv_ack       (inv_ack),
  .bar_valid     (bar_valid),
  .bar_kind      (bar_kind),
  .sb_snoop      (sb_snoop),
  .sb_mark       (sb_mark),
  .tag_inv_valid (tag_inv_valid),
  .tag_inv_line  (tag_inv_line),
  .tag_inv_ready (tag_inv_ready),
  .marked_count  (marked_count)
);

// File: tb/test_invq_barrier_top.sv
module test_invq_barrier_top;
  localparam int DEPTH  = 8;
  localparam int LINE_W = 26;
  localparam int CNT_W  = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // main instance
  logic              inv_valid = 0, bar_valid = 0, tag_ready = 0, ld_req = 0;
  logic [LINE_W-1:0] inv_line = '0;
  logic [1:0]        bar_kind = 2'b00;
  logic              inv_ready, inv_ack, sb_snoop, sb_mark, tag_valid, ld_go, load_stall;
  logic [LINE_W-1:0] tag_line;
  logic [CNT_W-1:0]  marked_count;

  invq_barrier_top #(.DEPTH(DEPTH), .LINE_W(LINE_W)) i_invq_barrier_top (
    .clk(clk), .rst(rst), .inv_valid(inv_valid), .inv_line(inv_line),
    .inv_ready(inv_ready), .inv_ack(inv_ack), .bar_valid(bar_valid),
    .bar_kind(bar_kind), .sb_snoop(sb_snoop), .sb_mark(sb_mark),
    .tag_inv_valid(tag_valid), .tag_inv_line(tag_line),
    .tag_inv_ready(tag_ready), .ld_req(ld_req), .ld_go(ld_go),
    .load_stall(load_stall), .marked_count(marked_count)
  );

  // full-drain variant
  logic              d_inv_valid = 0, d_bar_valid = 0, d_tag_ready = 0;
  logic [LINE_W-1:0] d_inv_line = '0;
  logic              d_inv_ready, d_inv_ack, d_sb_snoop, d_sb_mark, d_tag_valid, d_ld_go, d_load_stall;
  logic [LINE_W-1:0] d_tag_line;
  logic [CNT_W-1:0]  d_marked_count;

  invq_barrier_top #(.DEPTH(DEPTH), .LINE_W(LINE_W), .DRAIN_ON_BAR(1'b1)) i_invq_barrier_top_drain (
    .clk(clk), .rst(rst), .inv_valid(d_inv_valid), .inv_line(d_inv_line),
    .inv_ready(d_inv_ready), .inv_ack(d_inv_ack), .bar_valid(d_bar_valid),
    .bar_kind(2'b01), .sb_snoop(d_sb_snoop), .sb_mark(d_sb_mark),
    .tag_inv_valid(d_tag_valid), .tag_inv_line(d_tag_line),
    .tag_inv_ready(d_tag_ready), .ld_req(1'b1), .ld_go(d_ld_go),
    .load_stall(d_load_stall), .marked_count(d_marked_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every task begins and ends just after a falling edge
  task automatic push_one(input logic [LINE_W-1:0] line);
    inv_valid = 1'b1;
    inv_line  = line;
    #1 check("R2 ack on intake", 32'(inv_ack), 1);
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic barrier(input logic [1:0] kind);
    bar_valid = 1'b1;
    bar_kind  = kind;
    @(negedge clk);
    bar_valid = 1'b0;
    bar_kind  = 2'b00;
  endtask

  task automatic drain_all(input int n);
    tag_ready = 1'b1;
    repeat (n) @(negedge clk);
    tag_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 inv_ready", 32'(inv_ready), 1);
    check("R1 tag_inv_valid", 32'(tag_valid), 0);
    check("R1 load_stall", 32'(load_stall), 0);
    check("R1 marked_count", 32'(marked_count), 0);
    check("R1 sb pulses", {30'd0, sb_snoop, sb_mark}, 0);
  endtask

  task automatic t_fill_and_order;
    for (int i = 0; i < DEPTH; i++) push_one(LINE_W'(32'h100 + i));
    check("R2 full blocks intake", 32'(inv_ready), 0);
    inv_valid = 1'b1;
    inv_line  = LINE_W'(32'h1FF);
    #1 check("R2 no ack when full", 32'(inv_ack), 0);
    inv_valid = 1'b0;
    tag_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      check("R3 fifo order", 32'(tag_line), 32'h100 + i);
      @(negedge clk);
    end
    tag_ready = 1'b0;
    check("R3 empty after drain", 32'(tag_valid), 0);
    check("R2 ready again", 32'(inv_ready), 1);
  endtask

  task automatic t_mark_basic;
    for (int i = 0; i < 3; i++) push_one(LINE_W'(32'h200 + i));
    barrier(2'b01);
    check("R4 marks present entries", 32'(marked_count), 3);
    check("R5 stall raised", 32'(load_stall), 1);
    check("R10 read barrier snoop", {30'd0, sb_snoop, sb_mark}, 2);
    @(negedge clk);
    check("R10 snoop is a pulse", 32'(sb_snoop), 0);
    push_one(LINE_W'(32'h203));
    push_one(LINE_W'(32'h204));
    check("R7 later arrivals unmarked", 32'(marked_count), 3);
    check("R6 no forced drain", 32'(tag_line), 32'h200);
    ld_req = 1'b1;
    // the load targets line 0x202, the third marked entry
    for (int k = 0; k < 5; k++) begin
      #1;
      check("R3 order behind barrier", 32'(tag_line), 32'h200 + k);
      check("R6 marks count down", 32'(marked_count), (k < 3) ? 3 - k : 0);
      check("R12 load held while 0x202 pending", 32'(ld_go), (k >= 3) ? 1 : 0);
      if (k == 3) check("R7 stall ends with newer entries queued", 32'(tag_valid), 1);
      tag_ready = 1'b1;
      @(negedge clk);
    end
    tag_ready = 1'b0;
    ld_req    = 1'b0;
    check("R5 stall clear", 32'(load_stall), 0);
  endtask

  task automatic t_second_barrier;
    push_one(LINE_W'(32'h300));
    push_one(LINE_W'(32'h301));
    barrier(2'b01);
    push_one(LINE_W'(32'h302));
    push_one(LINE_W'(32'h303));
    check("R7 first mark only", 32'(marked_count), 2);
    barrier(2'b11);
    check("R8 second barrier marks all", 32'(marked_count), 4);
    check("R10 full barrier both", {30'd0, sb_snoop, sb_mark}, 3);
    drain_all(4);
    check("R6 marks gone", 32'(marked_count), 0);
    check("R5 stall low", 32'(load_stall), 0);
  endtask

  task automatic t_write_barrier;
    push_one(LINE_W'(32'h400));
    push_one(LINE_W'(32'h401));
    barrier(2'b10);
    check("R9 write leaves queue", 32'(marked_count), 0);
    check("R9 no stall", 32'(load_stall), 0);
    check("R10 write barrier mark", {30'd0, sb_snoop, sb_mark}, 1);
    drain_all(2);
  endtask

  task automatic t_same_cycle;
    push_one(LINE_W'(32'h500));
    push_one(LINE_W'(32'h501));
    tag_ready = 1'b1;
    inv_valid = 1'b1;
    inv_line  = LINE_W'(32'h502);
    bar_valid = 1'b1;
    bar_kind  = 2'b01;
    @(negedge clk);
    tag_ready = 1'b0;
    inv_valid = 1'b0;
    bar_valid = 1'b0;
    bar_kind  = 2'b00;
    check("R4 same-cycle intake marked", 32'(marked_count), 2);
    check("R3 head advanced", 32'(tag_line), 32'h501);
    bar_valid = 1'b1;
    bar_kind  = 2'b00;
    @(negedge clk);
    bar_valid = 1'b0;
    check("R10 kind 00 ignored marks", 32'(marked_count), 2);
    check("R10 kind 00 no pulses", {30'd0, sb_snoop, sb_mark}, 0);
    drain_all(1);
    check("R6 one removed", 32'(marked_count), 1);
    drain_all(1);
    check("R6 both removed", 32'(marked_count), 0);
  endtask

  task automatic t_drain_variant;
    for (int i = 0; i < 2; i++) begin
      d_inv_valid = 1'b1;
      d_inv_line  = LINE_W'(32'h600 + i);
      @(negedge clk);
    end
    d_inv_valid = 1'b0;
    d_bar_valid = 1'b1;
    @(negedge clk);
    d_bar_valid = 1'b0;
    check("R11 intake closed", 32'(d_inv_ready), 0);
    check("R11 stall on drain", 32'(d_load_stall), 1);
    d_inv_valid = 1'b1;
    #1 check("R11 no ack while draining", 32'(d_inv_ack), 0);
    d_inv_valid = 1'b0;
    d_tag_ready = 1'b1;
    @(negedge clk);
    check("R11 still draining", 32'(d_load_stall), 1);
    @(negedge clk);
    d_tag_ready = 1'b0;
    check("R11 stall released", 32'(d_load_stall), 0);
    check("R11 intake reopened", 32'(d_inv_ready), 1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fill_and_order();
    t_mark_basic();
    t_second_barrier();
    t_write_barrier();
    t_same_cycle();
    t_drain_variant();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule